// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, in one clock step, how a processor core enters a handler. The execute stage strobes `take_event` while it presents the following inputs:

- a pending exception code, or no code;
- an interrupt request, together with the vector answer from the interrupt controller;
- the live status word, PC, stack register, vector base and delay-slot state.

On the next clock edge the block writes three groups of results:

- the redirected PC and the new status word;
- the shadow copies of status, PC and stack register;
- the exception or interrupt event code.

In that same cycle it raises `handler_entered` for exactly one cycle.

An exception always wins over an interrupt. While the status word's block bit is set, two rules apply:

- Almost every exception is converted into a reset-class entry.
- An interrupt is dropped, unless it is flagged as a wake from the halted state.

The target address depends on the exception class:

- reset-class codes go to a fixed reset address;
- translation-miss codes go to vector base + 0x400;
- all other exceptions go to vector base + 0x100;
- interrupts go to vector base + 0x600.

Two codes also move the saved PC. An event inside a branch delay slot pulls the saved PC back to the branch. The trap code moves the saved PC forward past the trap instruction.

All pins are plain control and status signals. `take_event` is a single-cycle strobe with no back-pressure: the block accepts a strobe on every cycle and produces its result one cycle later. No valid/ready handshake is needed.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid` and `irq_req` are both high, the exception is taken. The interrupt is not consulted and `intevt` keeps its value.
- R2: When status bit 28 (block) is set, an exception code other than 0x1E0 is handled as code 0x000: `expevt` becomes 0x000 and the reset-class entry is used. Code 0x1E0 is handled unchanged.
- R3: When status bit 28 is set and no exception is pending, an interrupt is ignored unless `halt_wake` is high. An ignored interrupt leaves every output unchanged and gives no `handler_entered` pulse.
- R4: `intc_level` always equals status bits [7:4]. An interrupt with `intc_vec_valid` low is not taken.
- R5: On entry, `ssr` takes `sr_in` and `sgr` takes `r15_in`. `sr_out` is `sr_in` with bits 30 (mode), 29 (bank) and 28 (block) set.
- R6: If `dslot` or `dslot_cond` is high at entry, the saved PC is `pc_in - 2` and `clr_dslot` pulses together with `handler_entered`. Otherwise `clr_dslot` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set status bits [7:4] to 0xF and jump to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 jump to `vbr_in + 0x400`. Every other exception outside the reset class jumps to `vbr_in + 0x100`.
- R9: Exception code 0x160 (trap) saves `pc_in + 2`, corrected by R6 if it sits in a delay slot, and jumps to `vbr_in + 0x100`.
- R10: A taken interrupt writes `intc_vec` into `intevt` and jumps to `vbr_in + 0x600`. A taken exception writes its code into `expevt`.
- R11: All results and the `handler_entered` pulse appear one cycle after the `take_event` strobe. Without a strobe, no output changes.
- R12: After reset, the outputs are as follows:
  - `pc_out` = 0xA0000000;
  - `sr_out` = 0x700000F0;
  - all saved values and event codes are zero;
  - both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_event | input | 1 | Strobe: evaluate entry this cycle |
| exc_valid | input | 1 | An exception code is pending |
| exc_code | input | 12 | Pending exception code |
| irq_req | input | 1 | Hardware interrupt request |
| halt_wake | input | 1 | Interrupt arrived while the core was halted |
| intc_vec_valid | input | 1 | Controller has an unmasked vector |
| intc_vec | input | 12 | Controller vector |
| intc_level | output | 4 | Mask level shown to the controller |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | PC of the faulting/interrupted instruction |
| r15_in | input | 32 | Current stack register |
| vbr_in | input | 32 | Vector base |
| dslot | input | 1 | Instruction is in an unconditional delay slot |
| dslot_cond | input | 1 | Instruction is in a conditional delay slot |
| pc_out | output | 32 | Redirected PC |
| sr_out | output | 32 | Status word after entry |
| ssr | output | 32 | Saved status |
| spc | output | 32 | Saved PC |
| sgr | output | 32 | Saved stack register |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| handler_entered | output | 1 | One-cycle pulse on redirect |
| clr_dslot | output | 1 | One-cycle pulse: clear delay-slot flags |

## Verification
Every registered result is due on the first rising edge after the cycle that carries `take_event`. `intc_level` is combinational from `sr_in` and is due in the same cycle. The bench changes inputs and the strobe on the falling edge and lowers the strobe one half-cycle after the capturing edge. It then compares every output against its model at that same falling edge, which is one half-cycle after the result was registered. Idle cycles with active-looking inputs and no strobe are compared in the same way, to confirm that nothing moves.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Status word field positions; the handler code relies on them.
  localparam int SR_MD       = 30;
  localparam int SR_RB       = 29;
  localparam int SR_BL       = 28;
  localparam int SR_FD       = 15;
  localparam int SR_IMASK_LO = 4;

  // Event code values.
  localparam int unsigned CODE_RESET   = 'h000;
  localparam int unsigned CODE_EXEMPT  = 'h1E0;
  localparam int unsigned CODE_TRAP    = 'h160;

  localparam int N_RESET_CLASS = 3;
  localparam int unsigned RESET_CLASS [N_RESET_CLASS] = '{'h000, 'h020, 'h140};

  localparam int N_MISS_CLASS = 2;
  localparam int unsigned MISS_CLASS [N_MISS_CLASS] = '{'h040, 'h060};

  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_EXC  = 2'd1,
    ENT_IRQ  = 2'd2
  } entry_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              halt_wake,
  input  logic              intc_vec_valid,
  input  logic              blocked,
  output entry_kind_e       kind,
  output logic [CODE_W-1:0] eff_code
);
  localparam logic [CODE_W-1:0] EXEMPT = CODE_W'(CODE_EXEMPT);
  localparam logic [CODE_W-1:0] RST    = CODE_W'(CODE_RESET);

  logic irq_ok;

  always_comb begin
    // While blocked, exceptions escalate to reset (one code exempt).
    eff_code = (blocked && exc_code != EXEMPT) ? RST : exc_code;
    // Interrupts only when no exception, not blocked (or halt wake), unmasked.
    irq_ok   = !exc_valid && irq_req && (!blocked || halt_wake) && intc_vec_valid;
    if (exc_valid)   kind = ENT_EXC;
    else if (irq_ok) kind = ENT_IRQ;
    else             kind = ENT_NONE;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter int          MASK_W   = 4,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] MISS_OFF = 32'h0000_0400,
  parameter logic [31:0] GEN_OFF  = 32'h0000_0100,
  parameter logic [31:0] IRQ_OFF  = 32'h0000_0600
) (
  input  entry_kind_e       kind,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   sr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_dslot,
  output logic [XLEN-1:0]   target_pc,
  output logic [XLEN-1:0]   entry_sr,
  output logic [XLEN-1:0]   saved_pc
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(2);

  logic [N_RESET_CLASS-1:0] rst_hit;
  logic [N_MISS_CLASS-1:0]  miss_hit;
  logic is_reset, is_miss, is_trap;

  for (genvar i = 0; i < N_RESET_CLASS; i++) begin : g_rst
    assign rst_hit[i] = (code == CODE_W'(RESET_CLASS[i]));
  end
  for (genvar j = 0; j < N_MISS_CLASS; j++) begin : g_miss
    assign miss_hit[j] = (code == CODE_W'(MISS_CLASS[j]));
  end

  assign is_reset = |rst_hit;
  assign is_miss  = |miss_hit;
  assign is_trap  = (code == CODE_W'(CODE_TRAP));

  always_comb begin
    entry_sr = sr;
    entry_sr[SR_MD] = 1'b1;
    entry_sr[SR_RB] = 1'b1;
    entry_sr[SR_BL] = 1'b1;

    saved_pc = in_dslot ? (pc - PC_STEP) : pc;

    if (kind == ENT_IRQ) begin
      target_pc = vbr + XLEN'(IRQ_OFF);
    end else if (is_reset) begin
      entry_sr[SR_FD] = 1'b0;
      entry_sr[SR_IMASK_LO +: MASK_W] = '1;
      target_pc = XLEN'(RESET_PC);
    end else if (is_miss) begin
      target_pc = vbr + XLEN'(MISS_OFF);
    end else begin
      target_pc = vbr + XLEN'(GEN_OFF);
      if (is_trap) saved_pc = saved_pc + PC_STEP;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter int          MASK_W   = 4,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] MISS_OFF = 32'h0000_0400,
  parameter logic [31:0] GEN_OFF  = 32'h0000_0100,
  parameter logic [31:0] IRQ_OFF  = 32'h0000_0600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_event,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              halt_wake,
  input  logic              intc_vec_valid,
  input  logic [CODE_W-1:0] intc_vec,
  output logic [MASK_W-1:0] intc_level,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              dslot,
  input  logic              dslot_cond,
  output logic [XLEN-1:0]   pc_out,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt,
  output logic              handler_entered,
  output logic              clr_dslot
);
  localparam logic [XLEN-1:0] SR_RESET_VAL =
    (XLEN'(1) << SR_MD) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_BL) |
    (XLEN'((1 << MASK_W) - 1) << SR_IMASK_LO);

  entry_kind_e       kind;
  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   nxt_pc, nxt_sr, nxt_spc;
  logic              in_dslot, fire;

  assign intc_level = sr_in[SR_IMASK_LO +: MASK_W];
  assign in_dslot   = dslot | dslot_cond;
  assign fire       = take_event && (kind != ENT_NONE);

  exc_arbiter #(.CODE_W(CODE_W)) u_arb (
    .exc_valid      (exc_valid),
    .exc_code       (exc_code),
    .irq_req        (irq_req),
    .halt_wake      (halt_wake),
    .intc_vec_valid (intc_vec_valid),
    .blocked        (sr_in[SR_BL]),
    .kind           (kind),
    .eff_code       (eff_code)
  );

  exc_vector #(
    .XLEN(XLEN), .CODE_W(CODE_W), .MASK_W(MASK_W), .RESET_PC(RESET_PC),
    .MISS_OFF(MISS_OFF), .GEN_OFF(GEN_OFF), .IRQ_OFF(IRQ_OFF)
  ) u_vec (
    .kind      (kind),
    .code      (eff_code),
    .sr        (sr_in),
    .pc        (pc_in),
    .vbr       (vbr_in),
    .in_dslot  (in_dslot),
    .target_pc (nxt_pc),
    .entry_sr  (nxt_sr),
    .saved_pc  (nxt_spc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_out          <= XLEN'(RESET_PC);
      sr_out          <= SR_RESET_VAL;
      ssr             <= '0;
      spc             <= '0;
      sgr             <= '0;
      expevt          <= '0;
      intevt          <= '0;
      handler_entered <= 1'b0;
      clr_dslot       <= 1'b0;
    end else begin
      handler_entered <= fire;
      clr_dslot       <= fire && in_dslot;
      if (fire) begin
        pc_out <= nxt_pc;
        sr_out <= nxt_sr;
        ssr    <= sr_in;
        spc    <= nxt_spc;
        sgr    <= r15_in;
        if (kind == ENT_EXC) expevt <= eff_code;
        else                 intevt <= intc_vec;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          CODE_W  = 12,
  parameter logic [31:0] IRQ_OFF = 32'h0000_0600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_event,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic              irq_req,
  input logic              halt_wake,
  input logic [XLEN-1:0]   sr_in,
  input logic [XLEN-1:0]   vbr_in,
  input logic [XLEN-1:0]   pc_out,
  input logic [XLEN-1:0]   sr_out,
  input logic [CODE_W-1:0] expevt,
  input logic [CODE_W-1:0] intevt,
  input logic              handler_entered
);
  p_pulse_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    handler_entered |-> $past(take_event));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take_event |=> ($stable(pc_out) && $stable(sr_out) && !handler_entered));

  p_entry_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    handler_entered |-> (sr_out[SR_MD] && sr_out[SR_RB] && sr_out[SR_BL]));

  p_block_escalate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_entered && $past(exc_valid && sr_in[SR_BL] &&
                              exc_code != CODE_W'(CODE_EXEMPT)))
    |-> (expevt == CODE_W'(CODE_RESET)));

  p_irq_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_entered && $past(!exc_valid))
    |-> (pc_out == $past(vbr_in) + XLEN'(IRQ_OFF)));

  p_exc_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_entered && $past(exc_valid)) |-> $stable(intevt));

  p_block_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_event && !exc_valid && irq_req && sr_in[SR_BL] && !halt_wake)
    |=> !handler_entered);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .XLEN(XLEN), .CODE_W(CODE_W), .IRQ_OFF(IRQ_OFF)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .take_event      (take_event),
  .exc_valid       (exc_valid),
  .exc_code        (exc_code),
  .irq_req         (irq_req),
  .halt_wake       (halt_wake),
  .sr_in           (sr_in),
  .vbr_in          (vbr_in),
  .pc_out          (pc_out),
  .sr_out          (sr_out),
  .expevt          (expevt),
  .intevt          (intevt),
  .handler_entered (handler_entered)
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_event = 1'b0;
  logic        exc_valid = 1'b0;
  logic [11:0] exc_code = '0;
  logic        irq_req = 1'b0;
  logic        halt_wake = 1'b0;
  logic        intc_vec_valid = 1'b0;
  logic [11:0] intc_vec = '0;
  logic [3:0]  intc_level;
  logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
  logic        dslot = 1'b0, dslot_cond = 1'b0;
  logic [31:0] pc_out, sr_out, ssr, spc, sgr;
  logic [11:0] expevt, intevt;
  logic        handler_entered, clr_dslot;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Expected state
  logic [31:0] m_pc, m_sr, m_ssr, m_spc, m_sgr;
  logic [11:0] m_exp, m_int;
  logic        m_pulse, m_clr;

  always #2.5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .take_event(take_event),
    .exc_valid(exc_valid), .exc_code(exc_code), .irq_req(irq_req),
    .halt_wake(halt_wake), .intc_vec_valid(intc_vec_valid),
    .intc_vec(intc_vec), .intc_level(intc_level), .sr_in(sr_in),
    .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in), .dslot(dslot),
    .dslot_cond(dslot_cond), .pc_out(pc_out), .sr_out(sr_out), .ssr(ssr),
    .spc(spc), .sgr(sgr), .expevt(expevt), .intevt(intevt),
    .handler_entered(handler_entered), .clr_dslot(clr_dslot)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model of one strobed evaluation.
  task automatic model_step();
    logic [11:0] code;
    bit bl, tx, ti;
    bl   = sr_in[28];
    code = (bl && exc_code != 12'h1E0) ? 12'h000 : exc_code;
    tx   = exc_valid;
    ti   = !exc_valid && irq_req && (!bl || halt_wake) && intc_vec_valid;
    m_pulse = tx || ti;
    m_clr   = (tx || ti) && (dslot || dslot_cond);
    if (tx || ti) begin
      m_ssr = sr_in;
      m_sgr = r15_in;
      m_spc = (dslot || dslot_cond) ? pc_in - 32'd2 : pc_in;
      m_sr  = sr_in | 32'h7000_0000;
      if (tx) begin
        m_exp = code;
        if (code == 12'h000 || code == 12'h020 || code == 12'h140) begin
          m_sr[15]  = 1'b0;
          m_sr[7:4] = 4'hF;
          m_pc      = 32'hA000_0000;
        end else if (code == 12'h040 || code == 12'h060) begin
          m_pc = vbr_in + 32'h400;
        end else begin
          m_pc = vbr_in + 32'h100;
          if (code == 12'h160) m_spc = m_spc + 32'd2;
        end
      end else begin
        m_int = intc_vec;
        m_pc  = vbr_in + 32'h600;
      end
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "pc_out", pc_out, m_pc);
    check(tag, "sr_out", sr_out, m_sr);
    check(tag, "ssr", ssr, m_ssr);
    check(tag, "spc", spc, m_spc);
    check(tag, "sgr", sgr, m_sgr);
    check(tag, "expevt", {20'd0, expevt}, {20'd0, m_exp});
    check(tag, "intevt", {20'd0, intevt}, {20'd0, m_int});
    check(tag, "handler_entered", {31'd0, handler_entered}, {31'd0, m_pulse});
    check(tag, "clr_dslot", {31'd0, clr_dslot}, {31'd0, m_clr});
  endtask

  // Inputs already set at a falling edge; strobe for one cycle.
  task automatic fire_event(input string tag);
    take_event = 1'b1;
    model_step();
    @(negedge clk);
    take_event = 1'b0;
    compare_all(tag);
    @(negedge clk);
  endtask

  task automatic set_in(input bit ev, input logic [11:0] c, input bit iq,
                        input bit hw, input bit vv, input logic [11:0] v,
                        input logic [31:0] s, input bit d, input bit dc);
    exc_valid = ev; exc_code = c; irq_req = iq; halt_wake = hw;
    intc_vec_valid = vv; intc_vec = v; sr_in = s; dslot = d; dslot_cond = dc;
    pc_in = $urandom; r15_in = $urandom; vbr_in = $urandom & 32'hFFFF_FF00;
  endtask

  function automatic logic [11:0] pick_code(input int k);
    case (k)
      0: return 12'h000; 1: return 12'h020; 2: return 12'h040;
      3: return 12'h060; 4: return 12'h0A0; 5: return 12'h140;
      6: return 12'h160; 7: return 12'h180; 8: return 12'h1E0;
      default: return 12'h100;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    m_pc = 32'hA000_0000; m_sr = 32'h7000_00F0; m_ssr = 0; m_spc = 0;
    m_sgr = 0; m_exp = 0; m_int = 0; m_pulse = 0; m_clr = 0;
    compare_all("R12");

    // R4 level follows status mask field
    sr_in = 32'h0000_00A0; #1;
    check("R4", "intc_level", {28'd0, intc_level}, 32'hA);
    sr_in = 32'h0000_0050; #1;
    check("R4", "intc_level", {28'd0, intc_level}, 32'h5);
    @(negedge clk);

    // R1 exception wins over interrupt
    set_in(1, 12'h180, 1, 0, 1, 12'h3C0, 32'h0000_0030, 0, 0);
    fire_event("R1");
    // R10 plain interrupt
    set_in(0, 12'h000, 1, 0, 1, 12'h240, 32'h0000_8020, 0, 0);
    fire_event("R10");
    // R2 blocked exception escalates to reset
    set_in(1, 12'h0A0, 0, 0, 0, 12'h000, 32'h1000_8030, 0, 0);
    fire_event("R2");
    // R2 exempt code passes
    set_in(1, 12'h1E0, 0, 0, 0, 12'h000, 32'h1000_0000, 0, 0);
    fire_event("R2");
    // R3 blocked interrupt dropped, then taken with halt wake
    set_in(0, 12'h000, 1, 0, 1, 12'h320, 32'h1000_0000, 0, 0);
    fire_event("R3");
    set_in(0, 12'h000, 1, 1, 1, 12'h320, 32'h1000_0000, 0, 0);
    fire_event("R3");
    // R4 masked interrupt not taken
    set_in(0, 12'h000, 1, 0, 0, 12'h3A0, 32'h0000_0000, 0, 0);
    fire_event("R4");
    // R6 delay slot rewind (conditional and plain)
    set_in(1, 12'h180, 0, 0, 0, 12'h000, 32'h0000_0000, 0, 1);
    fire_event("R6");
    set_in(0, 12'h000, 1, 0, 1, 12'h200, 32'h0000_0000, 1, 0);
    fire_event("R6");
    // R9 trap advance, alone and in a delay slot
    set_in(1, 12'h160, 0, 0, 0, 12'h000, 32'h0000_0000, 0, 0);
    fire_event("R9");
    set_in(1, 12'h160, 0, 0, 0, 12'h000, 32'h0000_0000, 1, 0);
    fire_event("R9");
    // R8 miss offsets and general offset
    set_in(1, 12'h040, 0, 0, 0, 12'h000, 32'h0000_0000, 0, 0);
    fire_event("R8");
    set_in(1, 12'h060, 0, 0, 0, 12'h000, 32'h0000_0000, 0, 0);
    fire_event("R8");
    set_in(1, 12'h0C0, 0, 0, 0, 12'h000, 32'h0000_0000, 0, 0);
    fire_event("R8");
    // R7 reset class with FPU disable set and low mask
    set_in(1, 12'h020, 0, 0, 0, 12'h000, 32'h0000_8030, 0, 0);
    fire_event("R7");
    set_in(1, 12'h140, 0, 0, 0, 12'h000, 32'h0000_8010, 0, 0);
    fire_event("R7");
    set_in(1, 12'h000, 0, 0, 0, 12'h000, 32'h0000_8000, 0, 0);
    fire_event("R7");
    // R5 save of status and stack
    set_in(1, 12'h180, 0, 0, 0, 12'h000, 32'h0123_4567 & 32'h8FFF_FFFF, 0, 0);
    fire_event("R5");
    // R11 no strobe: nothing moves
    set_in(1, 12'h040, 1, 1, 1, 12'h111, 32'h0000_0000, 1, 1);
    m_pulse = 0; m_clr = 0;
    @(negedge clk);
    compare_all("R11");
    @(negedge clk);
    compare_all("R11");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      set_in($urandom % 3 == 0, pick_code($urandom % 10), $urandom % 2,
             $urandom % 4 == 0, $urandom % 4 != 0, 12'($urandom),
             $urandom, $urandom % 5 == 0, $urandom % 5 == 0);
      if ($urandom % 6 == 0) begin
        m_pulse = 0; m_clr = 0;
        @(negedge clk);
        compare_all("R11");
      end else begin
        fire_event("rand");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule